// File: doc/BRIEF.md
# Interrupt Flag and Edge Controller

This block is the interrupt section of a 6522-style peripheral adapter. It keeps seven pending-interrupt flags and seven matching enable bits. It watches four asynchronous control lines: A1, A2, B1 and B2. A control register selects which edge of each line sets that line's flag. It also selects whether the second line of each port (A2, B2) is an input at all. Two timers and a shift engine raise their flags with one-cycle set pulses. Accesses to the port A and port B handshake addresses clear the flags of that port's control lines. The active-low `irq_n` output goes low while any flag is both pending and enabled.

Software reaches the block over a small register bus: a 4-bit address, read and write strobes, and 8-bit write and read data. Read data is combinational while `bus_rd` is high. A read or write with side effects takes effect at the next rising clock edge.

Top module: `intr_flag_unit`

## Requirements
- R1: `irq_n` is 0 exactly when at least one of the seven flags is set while its enable bit is also set; otherwise it is 1.
- R2: A write to the enable register (address 0xE) with data bit 7 = 1 sets every enable bit whose data bit is 1. With data bit 7 = 0 it clears every enable bit whose data bit is 1. All other enable bits keep their value in both cases.
- R3: A read of the enable register returns the seven enable bits in bits 6..0, with bit 7 read as 1.
- R4: A read of the flag register (address 0xD) returns the seven flags in bits 6..0. Bit 7 reads 1 when any flag is both set and enabled.
- R5: A write to the flag register clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R6: Control register (address 0xC) bit 0 selects the edge of line A1 that sets flag bit 1: 1 selects rising, 0 selects falling. Bit 4 does the same for line B1 and flag bit 4.
- R7: Line A2 sets flag bit 0 only while control bit 3 is 0, on the edge chosen by control bit 2 (1 = rising). Line B2 sets flag bit 3 only while control bit 7 is 0, on the edge chosen by control bit 6.
- R8: A read or write at address 1 (port A handshake) clears flag bit 1. It also clears flag bit 0 unless control bit 3 = 0 and bit 1 = 1 (independent mode). A read or write at address 0 (port B handshake) clears flag bit 4. It also clears flag bit 3 unless control bit 7 = 0 and bit 5 = 1.
- R9: A one-cycle pulse on `tmr1_evt`, `tmr2_evt` or `sr_evt` sets flag bit 6, 5 or 2 respectively at the next clock edge. When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Reset clears the flags, the enable bits and the control register, so that `irq_n` is 1 after reset.
- R11: A control-line edge sets its flag at the third rising clock edge after the line changes, because of two synchroniser stages and one edge-history stage. Reads of addresses 0, 1 and any unused address return 0. The control register reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is active |
| ctl_a1 | input | 1 | Control line A1, asynchronous |
| ctl_a2 | input | 1 | Control line A2, asynchronous |
| ctl_b1 | input | 1 | Control line B1, asynchronous |
| ctl_b2 | input | 1 | Control line B2, asynchronous |
| tmr1_evt | input | 1 | Timer 1 underflow pulse |
| tmr2_evt | input | 1 | Timer 2 underflow pulse |
| sr_evt | input | 1 | Shift engine completion pulse |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions check on every cycle the following points:
- the set and clear semantics of an enable-register write;
- bit 7 forced high when the enable register is read;
- agreement between flag-register bit 7 and `irq_n` during a flag read;
- a timer pulse always leaving its flag set;
- a flag write clearing the addressed flag when no set competes.

Edge polarity and input-mode selection, the independent-mode exception for port accesses, and the set-over-clear priority can only be shown by the bench's scenarios. So can reset in the middle of a run. The bench sweeps every line, edge select, edge direction and mode, and all 128 enable patterns.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int FLAG_W   = 7;
    localparam int NUM_LINE = 4;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;

    // Flag bit positions
    localparam int FB_A2 = 0;
    localparam int FB_A1 = 1;
    localparam int FB_SR = 2;
    localparam int FB_B2 = 3;
    localparam int FB_B1 = 4;
    localparam int FB_T2 = 5;
    localparam int FB_T1 = 6;

    // Control line indices
    localparam int LN_A1 = 0;
    localparam int LN_A2 = 1;
    localparam int LN_B1 = 2;
    localparam int LN_B2 = 3;

    // Register addresses
    localparam logic [ADDR_W-1:0] AD_PORTB = 4'h0;
    localparam logic [ADDR_W-1:0] AD_PORTA = 4'h1;
    localparam logic [ADDR_W-1:0] AD_CTRL  = 4'hC;
    localparam logic [ADDR_W-1:0] AD_FLAG  = 4'hD;
    localparam logic [ADDR_W-1:0] AD_ENAB  = 4'hE;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] enab;
        logic [DATA_W-1:0] ctrl;
    } core_state_t;
endpackage

// File: rtl/ctl_edge_sync.sv
module ctl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // the last synchronised stage compared with its history stage
    assign rise =  st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
    assign fall = ~st_q.chain[STAGES-1] &  st_q.chain[STAGES];
endmodule

// File: rtl/intr_flag_core.sv
module intr_flag_core
    import intr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_flag,
    input  logic                wr_enab,
    input  logic                wr_ctrl,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                porta_acc,
    input  logic                portb_acc,
    input  logic [NUM_LINE-1:0] line_rise,
    input  logic [NUM_LINE-1:0] line_fall,
    input  logic                tmr1_evt,
    input  logic                tmr2_evt,
    input  logic                sr_evt,
    output logic [FLAG_W-1:0]   flags_q,
    output logic [FLAG_W-1:0]   enab_q,
    output logic [DATA_W-1:0]   ctrl_q
);
    core_state_t st_d, st_q;
    logic [FLAG_W-1:0] set_v, clr_v;
    logic a2_indep, b2_indep;

    always_comb begin
        st_d  = st_q;
        set_v = '0;
        clr_v = '0;

        a2_indep = ~st_q.ctrl[3] & st_q.ctrl[1];
        b2_indep = ~st_q.ctrl[7] & st_q.ctrl[5];

        // edge-driven sets
        set_v[FB_A1] = st_q.ctrl[0] ? line_rise[LN_A1] : line_fall[LN_A1];
        set_v[FB_B1] = st_q.ctrl[4] ? line_rise[LN_B1] : line_fall[LN_B1];
        set_v[FB_A2] = ~st_q.ctrl[3] &
                       (st_q.ctrl[2] ? line_rise[LN_A2] : line_fall[LN_A2]);
        set_v[FB_B2] = ~st_q.ctrl[7] &
                       (st_q.ctrl[6] ? line_rise[LN_B2] : line_fall[LN_B2]);
        set_v[FB_SR] = sr_evt;
        set_v[FB_T2] = tmr2_evt;
        set_v[FB_T1] = tmr1_evt;

        // clears
        if (wr_flag)
            clr_v = clr_v | wdata[FLAG_W-1:0];
        if (porta_acc) begin
            clr_v[FB_A1] = 1'b1;
            if (!a2_indep) clr_v[FB_A2] = 1'b1;
        end
        if (portb_acc) begin
            clr_v[FB_B1] = 1'b1;
            if (!b2_indep) clr_v[FB_B2] = 1'b1;
        end

        // set has priority
        st_d.flags = (st_q.flags & ~clr_v) | set_v;

        if (wr_enab) begin
            if (wdata[DATA_W-1]) st_d.enab = st_q.enab | wdata[FLAG_W-1:0];
            else                 st_d.enab = st_q.enab & ~wdata[FLAG_W-1:0];
        end

        if (wr_ctrl)
            st_d.ctrl = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;
    assign enab_q  = st_q.enab;
    assign ctrl_q  = st_q.ctrl;
endmodule

// File: rtl/intr_flag_unit.sv
module intr_flag_unit
    import intr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ctl_a1,
    input  logic              ctl_a2,
    input  logic              ctl_b1,
    input  logic              ctl_b2,
    input  logic              tmr1_evt,
    input  logic              tmr2_evt,
    input  logic              sr_evt,
    output logic              irq_n
);
    logic [NUM_LINE-1:0] line_in, line_rise, line_fall;
    logic [FLAG_W-1:0]   flag_vec, en_vec;
    logic [DATA_W-1:0]   ctrl_vec;
    logic                any_pend;
    logic                acc;

    assign line_in = {ctl_b2, ctl_b1, ctl_a2, ctl_a1};

    for (genvar i = 0; i < NUM_LINE; i++) begin : g_sync
        ctl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_in[i]),
            .rise (line_rise[i]),
            .fall (line_fall[i])
        );
    end

    assign acc = bus_rd | bus_wr;

    intr_flag_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_flag  (bus_wr && bus_addr == AD_FLAG),
        .wr_enab  (bus_wr && bus_addr == AD_ENAB),
        .wr_ctrl  (bus_wr && bus_addr == AD_CTRL),
        .wdata    (bus_wdata),
        .porta_acc(acc && bus_addr == AD_PORTA),
        .portb_acc(acc && bus_addr == AD_PORTB),
        .line_rise(line_rise),
        .line_fall(line_fall),
        .tmr1_evt (tmr1_evt),
        .tmr2_evt (tmr2_evt),
        .sr_evt   (sr_evt),
        .flags_q  (flag_vec),
        .enab_q   (en_vec),
        .ctrl_q   (ctrl_vec)
    );

    assign any_pend = |(flag_vec & en_vec);
    assign irq_n    = ~any_pend;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                AD_FLAG: bus_rdata = {any_pend, flag_vec};
                AD_ENAB: bus_rdata = {1'b1, en_vec};
                AD_CTRL: bus_rdata = ctrl_vec;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/intr_flag_chk.sv
module intr_flag_chk
    import intr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tmr1_evt,
    input logic              tmr2_evt,
    input logic              irq_n,
    input logic [FLAG_W-1:0] flags,
    input logic [FLAG_W-1:0] enables
);
    AST_ENAB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AD_ENAB && bus_wdata[7])
        |=> ((enables & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0]))); // R2

    AST_ENAB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AD_ENAB && !bus_wdata[7])
        |=> ((enables & $past(bus_wdata[6:0])) == '0)); // R2

    AST_ENAB_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == AD_ENAB) |-> bus_rdata[7]); // R3

    AST_FLAG_READ_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == AD_FLAG) |-> (bus_rdata[7] == !irq_n)); // R4

    AST_FLAG_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AD_FLAG && bus_wdata[5] && !tmr2_evt)
        |=> !flags[5]); // R5

    AST_T1_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr1_evt |=> flags[6]); // R9
endmodule

bind intr_flag_unit intr_flag_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .tmr1_evt (tmr1_evt),
    .tmr2_evt (tmr2_evt),
    .irq_n    (irq_n),
    .flags    (flag_vec),
    .enables  (en_vec)
);

// File: tb/intr_flag_unit_test.sv
module intr_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] lines = '0;   // 0 A1, 1 A2, 2 B1, 3 B2
    logic       tmr1_evt = 1'b0, tmr2_evt = 1'b0, sr_evt = 1'b0;
    logic       irq_n;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    intr_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctl_a1(lines[0]), .ctl_a2(lines[1]), .ctl_b1(lines[2]), .ctl_b2(lines[3]),
        .tmr1_evt(tmr1_evt), .tmr2_evt(tmr2_evt), .sr_evt(sr_evt), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 1) tmr1_evt = 1'b1;
        if (which == 2) tmr2_evt = 1'b1;
        if (which == 3) sr_evt = 1'b1;
        @(negedge clk);
        tmr1_evt = 1'b0; tmr2_evt = 1'b0; sr_evt = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] cv, expv;
        int fb;

        idle(3);
        rst_n = 1'b1;
        idle(2);
        // reset state (R10)
        check("R10 irq_n after reset", {7'd0, irq_n}, 8'h01);
        rd(4'hD, d); check("R10 flags after reset", d, 8'h00);
        rd(4'hE, d); check("R10 enables after reset (R3)", d, 8'h80);
        rd(4'hC, d); check("R10 control after reset", d, 8'h00);

        // edge sweep (R6, R7, R11)
        for (int ln = 0; ln < 4; ln++)
            for (int sel = 0; sel < 2; sel++)
                for (int dir = 0; dir < 2; dir++)
                    for (int mode = 0; mode < 2; mode++) begin
                        case (ln)
                            0: begin cv = 8'(sel) | 8'(mode << 3); fb = 1; end
                            1: begin cv = 8'(sel << 2) | 8'(mode << 3); fb = 0; end
                            2: begin cv = 8'(sel << 4) | 8'(mode << 7); fb = 4; end
                            default: begin cv = 8'(sel << 6) | 8'(mode << 7); fb = 3; end
                        endcase
                        lines[ln] = ~1'(dir);
                        idle(5);
                        wr(4'hC, cv);
                        wr(4'hD, 8'h7F);
                        lines[ln] = 1'(dir);
                        idle(4);
                        rd(4'hD, d);
                        expv = ((dir == sel) && ((ln % 2 == 0) || mode == 0)) ? 8'(1 << fb) : 8'h00;
                        check((ln % 2 == 0) ? "R6 edge select" : "R7 mode/edge", d & 8'h7F, expv);
                    end
        lines = '0;
        idle(5);

        // control readback (R11)
        wr(4'hC, 8'hA5); rd(4'hC, d); check("R11 control readback", d, 8'hA5);
        rd(4'h5, d); check("R11 unused address reads 0", d, 8'h00);
        rd(4'h1, d); check("R11 port A address reads 0", d, 8'h00);

        // port A clear, independent then normal (R8)
        wr(4'hC, 8'h07); wr(4'hD, 8'h7F);
        lines[0] = 1'b1; lines[1] = 1'b1; idle(5);
        rd(4'hD, d); check("R8 port A flags set", d & 8'h7F, 8'h03);
        rd(4'h1, d);
        rd(4'hD, d); check("R8 port A read keeps independent A2", d & 8'h7F, 8'h01);
        lines[0] = 1'b0; lines[1] = 1'b0; idle(5);
        wr(4'hC, 8'h05); wr(4'hD, 8'h7F);
        lines[0] = 1'b1; lines[1] = 1'b1; idle(5);
        wr(4'h1, 8'h00);
        rd(4'hD, d); check("R8 port A write clears both", d & 8'h7F, 8'h00);

        // port B clear (R8)
        wr(4'hC, 8'h70); wr(4'hD, 8'h7F);
        lines[2] = 1'b1; lines[3] = 1'b1; idle(5);
        rd(4'hD, d); check("R8 port B flags set", d & 8'h7F, 8'h18);
        rd(4'h0, d);
        rd(4'hD, d); check("R8 port B read keeps independent B2", d & 8'h7F, 8'h08);
        lines[2] = 1'b0; lines[3] = 1'b0; idle(5);
        wr(4'hC, 8'h50); wr(4'hD, 8'h7F);
        lines[2] = 1'b1; lines[3] = 1'b1; idle(5);
        wr(4'h0, 8'h00);
        rd(4'hD, d); check("R8 port B write clears both", d & 8'h7F, 8'h00);
        lines = '0; idle(5);

        // enable sweep (R2, R3)
        for (int v = 0; v < 128; v++) begin
            wr(4'hE, 8'h7F);
            wr(4'hE, 8'h80 | 8'(v));
            rd(4'hE, d); check("R2 enable set", d, 8'h80 | 8'(v));
            wr(4'hE, 8'h55);
            rd(4'hE, d); check("R2 enable clear", d, 8'h80 | (8'(v) & 8'h2A));
        end

        // timers, irq, flag clear, priority (R1, R4, R5, R9)
        wr(4'hE, 8'h7F); wr(4'hD, 8'h7F);
        pulse(1);
        rd(4'hD, d); check("R9 timer1 sets bit 6 (R4 no enable)", d, 8'h40);
        check("R1 irq idle when not enabled", {7'd0, irq_n}, 8'h01);
        wr(4'hE, 8'hC0);
        check("R1 irq asserted", {7'd0, irq_n}, 8'h00);
        rd(4'hD, d); check("R4 bit7 with enabled flag", d, 8'hC0);
        pulse(2); pulse(3);
        rd(4'hD, d); check("R9 timer2 and shift set", d, 8'hE4);
        wr(4'hD, 8'h20);
        rd(4'hD, d); check("R5 flag write clears bit 5", d, 8'hC4);
        wr(4'hD, 8'h40);
        rd(4'hD, d); check("R5 flag write clears bit 6", d, 8'h04);
        check("R1 irq released", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        tmr1_evt = 1'b1; bus_addr = 4'hD; bus_wdata = 8'h40; bus_wr = 1'b1;
        @(negedge clk);
        tmr1_evt = 1'b0; bus_wr = 1'b0;
        rd(4'hD, d); check("R9 set wins over clear", d, 8'hC4);

        // reset mid-run (R10)
        wr(4'hC, 8'h5A);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        check("R10 irq after mid reset", {7'd0, irq_n}, 8'h01);
        rd(4'hD, d); check("R10 flags after mid reset", d, 8'h00);
        rd(4'hE, d); check("R10 enables after mid reset", d, 8'h80);
        rd(4'hC, d); check("R10 control after mid reset", d, 8'h00);

        summary();
        $finish;
    end
endmodule